// File: doc/BRIEF.md
# Instruction Queue Fetch Tracker

This block keeps the bookkeeping for one instruction ring. Software rings a doorbell by adding a number of 64-bit words to a 20-bit pending-word counter. Whenever the queue is enabled, at least one whole instruction (8 words, 64 bytes) is pending and the in-flight window has room, the block raises a fetch request. The request carries the current line-aligned read address. Each granted request consumes 8 words, moves the read pointer forward by one 64-byte line and adds one to the in-flight count. Completion pulses from the execution side lower that count.

Software clears a pending count by adding 2^20 minus the value it reads back, so that the counter wraps to zero. Any add that carries out of the counter raises a sticky overflow flag, which software then clears explicitly. The start address may only be loaded while the queue is disabled and nothing is in flight. A load at any other time is dropped and recorded in a sticky error flag. A quiescent output tells software when reconfiguration is safe.

Top module: `iq_fetch_tracker`

## Requirements
- R1: After reset the pending count is 0, the queue is disabled, the in-flight count is 0, both sticky flags are 0, the read address is 0, no fetch is requested and quiescent is 1.
- R2: A doorbell add (db_add_en=1) adds db_add_val to the pending count, modulo 2^20; db_count shows the new value the cycle after.
- R3: fetch_req is 1 exactly when the queue is enabled, db_count >= 8 and inflight < 255; a fetch is issued in a cycle where fetch_req and fetch_gnt are both 1. Clearing the enable removes fetch_req from the next cycle on.
- R4: An issued fetch lowers the pending count by 8. If a doorbell add falls in the same cycle, the count becomes count + add - 8.
- R5: fetch_addr equals next_addr. Its low 6 bits are always 0. It grows by 64 (modulo 2^49) after each issued fetch.
- R6: When count + add - consumed reaches or passes 2^20, db_ovf becomes 1 and the count keeps the low 20 bits. db_ovf stays 1 until a cycle with db_ovf_clr=1 and no new overflow; a new overflow in the same cycle as the clear leaves it at 1.
- R7: Adding 2^20 minus the current count brings the count to exactly 0 (and raises db_ovf by R6).
- R8: inflight grows by 1 per issued fetch and drops by 1 per inst_done. Both in one cycle leave it unchanged. inst_done while inflight is 0 is ignored.
- R9: base_wr loads next_addr with {base_line, 6'b0} only while the queue is disabled and inflight is 0. Otherwise the write is ignored and cfg_err becomes 1. cfg_err stays 1 until cfg_err_clr is asserted in a cycle without a rejected write; a rejected write wins over a clear in the same cycle.
- R10: quiescent is 1 exactly when the queue is disabled and inflight is 0.
- R11: q_ena_wr=1 sets the enable to q_ena_val from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_add_en | input | 1 | Doorbell add strobe |
| db_add_val | input | 20 | Words to add to the pending count |
| db_ovf_clr | input | 1 | Clear pulse for the overflow flag |
| q_ena_wr | input | 1 | Enable write strobe |
| q_ena_val | input | 1 | New enable value |
| base_wr | input | 1 | Start-address write strobe |
| base_line | input | 43 | Start address bits 48:6 |
| cfg_err_clr | input | 1 | Clear pulse for the configuration error flag |
| fetch_gnt | input | 1 | Memory side accepts the fetch request |
| inst_done | input | 1 | One in-flight instruction has completed |
| db_count | output | 20 | Pending words |
| db_ovf | output | 1 | Sticky doorbell overflow flag |
| q_ena | output | 1 | Queue enable |
| next_addr | output | 49 | Next address to be fetched |
| cfg_err | output | 1 | Sticky rejected-write flag |
| fetch_req | output | 1 | Fetch request |
| fetch_addr | output | 49 | Byte address of the requested instruction |
| inflight | output | 8 | Instructions fetched and not yet completed |
| quiescent | output | 1 | Disabled and nothing in flight |

## Verification
The counters update on collisions, and the bench aims for them. A doorbell add can land in the same cycle as a granted fetch, so the count moves by add minus 8. That same collision decides whether the sum overflows. The bench provokes it in long pseudo-random sweeps, with many adds sitting near 2^20, and in directed runs. It judges each cycle against an arithmetic model of the count, the overflow flag, the in-flight count and the address. The other collision pairs an issued fetch with a completion pulse, including at the 255 ceiling and at zero, and a flag set with its clear pulse. Each is forced directly and checked the cycle after.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
    parameter int CNT_W      = 20;   // pending-word counter width
    parameter int INST_WORDS = 8;    // words consumed per instruction
    parameter int INFL_W     = 8;    // in-flight counter width
    parameter int ADDR_W     = 49;   // byte address width
    parameter int LINE_LSB   = 6;    // log2 of instruction size in bytes

    localparam int PTR_W    = ADDR_W - LINE_LSB;
    localparam int INFL_MAX = (1 << INFL_W) - 1;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [INFL_W-1:0] infl_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef struct packed {
        cnt_t count;
        logic ovf;
    } db_state_t;

    typedef struct packed {
        logic ena;
        logic cfg_err;
    } ctl_state_t;
endpackage

// File: rtl/iqf_doorbell.sv
module iqf_doorbell
    import iqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic add_en,
    input  cnt_t add_val,
    input  logic consume,
    input  logic ovf_clr,
    output cnt_t count,
    output logic ovf,
    output logic has_inst
);
    localparam int WW = CNT_W + 1;

    db_state_t st_d, st_q;
    logic [WW-1:0] wide;

    always_comb begin
        st_d = st_q;
        wide = {1'b0, st_q.count}
             + (add_en  ? {1'b0, add_val}    : WW'(0))
             - (consume ? WW'(INST_WORDS)    : WW'(0));
        st_d.count = wide[CNT_W-1:0];
        if (wide[CNT_W])
            st_d.ovf = 1'b1;
        else if (ovf_clr)
            st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count    = st_q.count;
    assign ovf      = st_q.ovf;
    assign has_inst = (st_q.count >= cnt_t'(INST_WORDS));
endmodule

// File: rtl/iqf_inflight.sv
module iqf_inflight
    import iqf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inc,
    input  logic  dec,
    output infl_t count,
    output logic  full,
    output logic  zero
);
    infl_t cnt_d, cnt_q;
    logic  dec_ok;

    always_comb begin
        dec_ok = dec && (cnt_q != '0);
        cnt_d  = cnt_q;
        if (inc && !dec_ok)
            cnt_d = cnt_q + infl_t'(1);
        else if (!inc && dec_ok)
            cnt_d = cnt_q - infl_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign full  = (cnt_q == infl_t'(INFL_MAX));
    assign zero  = (cnt_q == '0);
endmodule

// File: rtl/iqf_line_ptr.sv
module iqf_line_ptr
    import iqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  ptr_t load_val,
    input  logic advance,
    output ptr_t ptr
);
    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load)
            ptr_d = load_val;
        else if (advance)
            ptr_d = ptr_q + ptr_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/iq_fetch_tracker.sv
module iq_fetch_tracker
    import iqf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                db_add_en,
    input  logic [CNT_W-1:0]    db_add_val,
    input  logic                db_ovf_clr,
    input  logic                q_ena_wr,
    input  logic                q_ena_val,
    input  logic                base_wr,
    input  logic [PTR_W-1:0]    base_line,
    input  logic                cfg_err_clr,
    input  logic                fetch_gnt,
    input  logic                inst_done,
    output logic [CNT_W-1:0]    db_count,
    output logic                db_ovf,
    output logic                q_ena,
    output logic [ADDR_W-1:0]   next_addr,
    output logic                cfg_err,
    output logic                fetch_req,
    output logic [ADDR_W-1:0]   fetch_addr,
    output logic [INFL_W-1:0]   inflight,
    output logic                quiescent
);
    ctl_state_t ctl_d, ctl_q;
    logic has_inst, infl_full, infl_zero;
    logic busy, base_ok, issue;
    ptr_t line_ptr;

    // Issue decision: enabled, a whole instruction pending, window not full
    assign fetch_req = ctl_q.ena && has_inst && !infl_full;
    assign issue     = fetch_req && fetch_gnt;
    assign busy      = ctl_q.ena || !infl_zero;
    assign base_ok   = base_wr && !busy;

    always_comb begin
        ctl_d = ctl_q;
        if (q_ena_wr)
            ctl_d.ena = q_ena_val;
        if (base_wr && busy)
            ctl_d.cfg_err = 1'b1;
        else if (cfg_err_clr)
            ctl_d.cfg_err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    iqf_doorbell u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (db_add_en),
        .add_val  (db_add_val),
        .consume  (issue),
        .ovf_clr  (db_ovf_clr),
        .count    (db_count),
        .ovf      (db_ovf),
        .has_inst (has_inst)
    );

    iqf_inflight u_infl (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (issue),
        .dec   (inst_done),
        .count (inflight),
        .full  (infl_full),
        .zero  (infl_zero)
    );

    iqf_line_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (base_ok),
        .load_val (base_line),
        .advance  (issue),
        .ptr      (line_ptr)
    );

    assign next_addr  = {line_ptr, {LINE_LSB{1'b0}}};
    assign fetch_addr = next_addr;
    assign q_ena      = ctl_q.ena;
    assign cfg_err    = ctl_q.cfg_err;
    assign quiescent  = !ctl_q.ena && infl_zero;
endmodule

// File: rtl/iqf_checker.sv
module iqf_checker
    import iqf_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                db_add_en,
    input logic                db_ovf_clr,
    input logic                base_wr,
    input logic                fetch_gnt,
    input logic                inst_done,
    input logic [CNT_W-1:0]    db_count,
    input logic                db_ovf,
    input logic                q_ena,
    input logic [ADDR_W-1:0]   next_addr,
    input logic                cfg_err,
    input logic                fetch_req,
    input logic [INFL_W-1:0]   inflight,
    input logic                quiescent
);
    logic issue;
    assign issue = fetch_req && fetch_gnt;

    a_r3_req_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (q_ena && db_count >= CNT_W'(INST_WORDS) && inflight != INFL_W'(INFL_MAX)));

    a_r4_issue_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !db_add_en) |=> db_count == $past(db_count) - CNT_W'(INST_WORDS));

    a_r5_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> next_addr == $past(next_addr) + ADDR_W'(1 << LINE_LSB));

    a_r8_inflight_up: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !inst_done) |=> inflight == $past(inflight) + INFL_W'(1));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (db_ovf && !db_ovf_clr) |=> db_ovf);

    a_r9_busy_write_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !q_ena && inflight != '0 && !issue) |=> (cfg_err && $stable(next_addr)));

    a_r10_quiescent: assert property (@(posedge clk) disable iff (!rst_n)
        quiescent |-> (!q_ena && inflight == '0));
endmodule

bind iq_fetch_tracker iqf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .db_add_en  (db_add_en),
    .db_ovf_clr (db_ovf_clr),
    .base_wr    (base_wr),
    .fetch_gnt  (fetch_gnt),
    .inst_done  (inst_done),
    .db_count   (db_count),
    .db_ovf     (db_ovf),
    .q_ena      (q_ena),
    .next_addr  (next_addr),
    .cfg_err    (cfg_err),
    .fetch_req  (fetch_req),
    .inflight   (inflight),
    .quiescent  (quiescent)
);

// File: tb/tb_iq_fetch_tracker.sv
module tb_iq_fetch_tracker;
    localparam longint CMOD = 64'd1 << 20;
    localparam longint AMOD = 64'd1 << 49;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic db_add_en = 0, db_ovf_clr = 0, q_ena_wr = 0, q_ena_val = 0;
    logic base_wr = 0, cfg_err_clr = 0, fetch_gnt = 0, inst_done = 0;
    logic [19:0] db_add_val = '0;
    logic [42:0] base_line = '0;
    logic [19:0] db_count;
    logic db_ovf, q_ena, cfg_err, fetch_req, quiescent;
    logic [48:0] next_addr, fetch_addr;
    logic [7:0] inflight;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // bench model
    longint m_cnt = 0, m_infl = 0, m_addr = 0;
    bit m_ovf = 0, m_ena = 0, m_err = 0;

    always #4 clk = ~clk;

    iq_fetch_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .db_add_en(db_add_en), .db_add_val(db_add_val), .db_ovf_clr(db_ovf_clr),
        .q_ena_wr(q_ena_wr), .q_ena_val(q_ena_val),
        .base_wr(base_wr), .base_line(base_line), .cfg_err_clr(cfg_err_clr),
        .fetch_gnt(fetch_gnt), .inst_done(inst_done),
        .db_count(db_count), .db_ovf(db_ovf), .q_ena(q_ena), .next_addr(next_addr),
        .cfg_err(cfg_err), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .inflight(inflight), .quiescent(quiescent)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_regs();
        chk(db_count == m_cnt[19:0], "R2/R4/R6 db_count", db_count, m_cnt);
        chk(db_ovf == m_ovf, "R6 db_ovf", db_ovf, m_ovf);
        chk(inflight == m_infl[7:0], "R8 inflight", inflight, m_infl);
        chk(q_ena == m_ena, "R11 q_ena", q_ena, m_ena);
        chk(next_addr == m_addr[48:0], "R5/R9 next_addr", next_addr, m_addr);
        chk(cfg_err == m_err, "R9 cfg_err", cfg_err, m_err);
        chk(quiescent == (!m_ena && m_infl == 0), "R10 quiescent", quiescent, !m_ena && m_infl == 0);
    endtask

    // One cycle: drive at negedge, check request, step model, check registers next negedge
    task automatic cyc(input bit dbe, input longint dbv, input bit gnt, input bit done,
                       input bit ee, input bit ev, input bit be, input longint bv,
                       input bit oclr, input bit eclr);
        bit busy, req, iss;
        longint sum;
        db_add_en = dbe; db_add_val = dbv[19:0]; fetch_gnt = gnt; inst_done = done;
        q_ena_wr = ee; q_ena_val = ev; base_wr = be; base_line = bv[42:0];
        db_ovf_clr = oclr; cfg_err_clr = eclr;
        #1;
        busy = m_ena || (m_infl != 0);
        req  = m_ena && (m_cnt >= 8) && (m_infl < 255);
        iss  = req && gnt;
        chk(fetch_req == req, "R3 fetch_req", fetch_req, req);
        chk(fetch_addr == m_addr[48:0], "R5 fetch_addr", fetch_addr, m_addr);
        sum = m_cnt + (dbe ? (dbv % CMOD) : 0) - (iss ? 8 : 0);
        if (sum >= CMOD) m_ovf = 1; else if (oclr) m_ovf = 0;
        m_cnt = sum % CMOD;
        if (iss && !(done && m_infl != 0)) m_infl++;
        else if (!iss && done && m_infl != 0) m_infl--;
        if (be && !busy) m_addr = (bv % (64'd1 << 43)) << 6;
        else if (iss) m_addr = (m_addr + 64) % AMOD;
        if (be && busy) m_err = 1; else if (eclr) m_err = 0;
        if (ee) m_ena = ev;
        @(negedge clk);
        check_regs();
    endtask

    task automatic idle(); cyc(0,0,0,0,0,0,0,0,0,0); endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk(fetch_req == 0, "R1 fetch_req after reset", fetch_req, 0);
        check_regs();
        @(negedge clk);

        // R2: doorbell adds with queue disabled
        for (int k = 0; k < 16; k++) cyc(1, k * 8, 1, 0, 0,0, 0,0, 0,0);
        cyc(1, 3, 0, 0, 0,0, 0,0, 0,0);
        // R7: wrap the count back to zero, overflow raised, then cleared
        cyc(1, CMOD - m_cnt, 0, 0, 0,0, 0,0, 0,0);
        chk(db_count == 0, "R7 count wrapped to zero", db_count, 0);
        cyc(0, 0, 0, 0, 0,0, 0,0, 1,0);
        // R6: overflow boundary, set beats clear
        cyc(1, CMOD - 8, 0, 0, 0,0, 0,0, 0,0);
        cyc(1, 7, 0, 0, 0,0, 0,0, 0,0);
        cyc(1, 1, 0, 0, 0,0, 0,0, 1,0);
        chk(db_ovf == 1, "R6 set wins over clear", db_ovf, 1);
        cyc(0, 0, 0, 0, 0,0, 0,0, 1,0);

        // R9: idle load accepted, busy load rejected, error set beats clear
        cyc(0, 0, 0, 0, 0,0, 1, 43'h1234_5678, 0,0);
        cyc(0, 0, 0, 0, 1,1, 0,0, 0,0);
        cyc(0, 0, 0, 0, 0,0, 1, 43'h7, 0,1);
        cyc(0, 0, 0, 0, 0,0, 0,0, 0,1);

        // R4/R5: add collides with issue; R3/R8 saturate in-flight at 255
        cyc(1, 8, 1, 0, 0,0, 0,0, 0,0);
        cyc(1, 255 * 8 + 64, 1, 0, 0,0, 0,0, 0,0);
        for (int k = 0; k < 260; k++) cyc(0, 0, 1, 0, 0,0, 0,0, 0,0);
        chk(inflight == 255, "R3 in-flight ceiling", inflight, 255);
        cyc(0, 0, 1, 1, 0,0, 0,0, 0,0);
        cyc(0, 0, 1, 1, 0,0, 0,0, 0,0);
        chk(inflight == 254, "R8 issue and done together", inflight, 254);
        // R3: disable stops requests, then drain to quiescent
        cyc(0, 0, 1, 0, 1,0, 0,0, 0,0);
        for (int k = 0; k < 260; k++) cyc(0, 0, 1, 1, 0,0, 0,0, 0,0);
        chk(quiescent == 1, "R10 drained", quiescent, 1);
        cyc(0, 0, 0, 1, 0,0, 0,0, 0,0);

        // Pseudo-random sweep over all inputs
        r = 32'h1ace_b00c;
        for (int k = 0; k < 4000; k++) begin
            longint v;
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            v = (r[31:28] == 0) ? (CMOD - 8 - 8 * r[26:24]) : 8 * r[8:5];
            cyc(r[3] & r[4], v, r[0] | r[1], r[2] & r[27],
                r[12:9] == 0, r[13] | r[14], r[18:15] == 0, {r[30:19], 6'h15},
                r[20] & r[21], r[22] & r[23]);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule